// File: doc/BRIEF.md
# Alternating-Branch Clock Root Selector

This block is a clock root slice that picks one of eight source clocks and divides it down. Internally it keeps two complete branches, each with its own source select, gate and pre-divider. A hidden toggle decides which branch feeds a shared post-divider. Software sees only one logical source register. Every accepted source write lands on the branch that is idle at that moment, and the toggle then hands the output to it. The branch that was driving keeps its old select.

Clocks are modelled as single-cycle tick strobes in the host clock domain. A tick on `src_tick[k]` means one edge of source k, and each pulse on `clk_out_tick` is one edge of the divided root. Writing the same source index twice in a row leaves both branches on that source. After that, no later write depends on an input that has since stopped. A per-input valid vector gates writes: the block rejects a write that requests a stopped source. It flags a write whose idle branch still points at a stopped source. A parameter selects the core variant, which has no pre-dividers.

Top module: `ppc_clk_root`

## Requirements
- R1: After reset both branch selects read 0, the toggle reads 0 (branch A drives), the output and both flags are low, and the slice is disabled.
- R2: An accepted source write (wr_addr=0, index in wr_data[2:0]) loads the index into the idle branch's select and flips the toggle. If the toggle is 0 the idle branch is B; if it is 1 the idle branch is A. The other select is unchanged. Without a source write, toggle and selects hold.
- R3: Two accepted writes of the same index in a row leave rd_sel_a and rd_sel_b both equal to that index.
- R4: A source write whose requested index has src_valid low changes no state and raises wr_reject for one cycle, visible one cycle after the write.
- R5: A source write while the idle branch's current select has src_valid low raises err_src_inactive for one cycle, visible one cycle after the write. Acceptance is decided by R4 alone.
- R6: With the slice enabled (wr_addr=3, wr_data[0]=1), clk_out_tick pulses once per (pre+1)*(post+1) ticks of the driving branch's source. pre is written at wr_addr=1 from wr_data[2:0], and post at wr_addr=2 from wr_data[5:0]. A pulse appears one cycle after the completing tick.
- R7: With parameter CORE=1 the pre-dividers are bypassed, and the output divides by (post+1) only.
- R8: With the slice disabled, clk_out_tick stays low from the second cycle after the disabling write, and all divider counters are cleared.
- R9: Ticks on inputs other than the driving branch's selected source have no effect on the output.
- R10: Writing the pre-divide value restarts both branch counters, and writing the post-divide value restarts the post counter, even when the value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | 8 | One tick strobe per source clock |
| src_valid | input | 8 | Source k is running when bit k is high |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 2 | 0 source, 1 pre-divide, 2 post-divide, 3 enable |
| wr_data | input | 6 | Write value |
| clk_out_tick | output | 1 | Divided root clock tick |
| rd_active | output | 1 | Toggle: 0 branch A drives, 1 branch B drives |
| rd_sel_a | output | 3 | Branch A source select |
| rd_sel_b | output | 3 | Branch B source select |
| wr_reject | output | 1 | Pulse: source write refused |
| err_src_inactive | output | 1 | Pulse: idle branch pointed at a stopped source |

## Verification
The bench walks a write sequence with repeated indices. A design that writes the active branch instead of the idle one, or that skips the toggle flip, leaves the readback wrong after the repeat. A design that moves a branch on a rejected write changes the selects. A stale-source write with a valid target must raise the error flag yet still be accepted. That exposes any design that ties rejection to the error check. Divider runs use exact tick counts. Leaking idle-branch ticks, skipping the counter restart on a rewrite with the same value, or keeping the pre-divider in the core variant all shift the pulse counts.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    typedef enum logic [1:0] {
        ADDR_SRC  = 2'd0,
        ADDR_PRE  = 2'd1,
        ADDR_POST = 2'd2,
        ADDR_EN   = 2'd3
    } ppc_addr_e;
endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
    import ppc_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int SEL_W  = 3,
    parameter int PRE_W  = 3,
    parameter int POST_W = 6,
    parameter int DATA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_valid,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              active,
    output logic [SEL_W-1:0]  sel_a,
    output logic [SEL_W-1:0]  sel_b,
    output logic [PRE_W-1:0]  pre_val,
    output logic [POST_W-1:0] post_val,
    output logic              enable,
    output logic [1:0]        restart_br,
    output logic              restart_post,
    output logic              reject,
    output logic              stale_err
);
    typedef struct packed {
        logic              active;
        logic [SEL_W-1:0]  sel_a;
        logic [SEL_W-1:0]  sel_b;
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
        logic              en;
        logic              rej;
        logic              err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [SEL_W-1:0] req_idx;
    logic [SEL_W-1:0] idle_sel;
    logic             is_src;
    logic             accept;

    always_comb begin
        st_d         = st_q;
        req_idx      = wr_data[SEL_W-1:0];
        idle_sel     = st_q.active ? st_q.sel_a : st_q.sel_b;
        is_src       = wr_en && (ppc_addr_e'(wr_addr) == ADDR_SRC);
        accept       = is_src && src_valid[req_idx];
        restart_br   = 2'b00;
        restart_post = 1'b0;
        st_d.rej     = is_src && !src_valid[req_idx];
        st_d.err     = is_src && !src_valid[idle_sel];
        if (accept) begin
            if (st_q.active) begin
                st_d.sel_a    = req_idx;
                restart_br[0] = 1'b1;
            end else begin
                st_d.sel_b    = req_idx;
                restart_br[1] = 1'b1;
            end
            st_d.active = !st_q.active;
        end
        if (wr_en) begin
            unique case (ppc_addr_e'(wr_addr))
                ADDR_PRE: begin
                    st_d.pre   = wr_data[PRE_W-1:0];
                    restart_br = 2'b11;
                end
                ADDR_POST: begin
                    st_d.post    = wr_data[POST_W-1:0];
                    restart_post = 1'b1;
                end
                ADDR_EN:  st_d.en = wr_data[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active    = st_q.active;
    assign sel_a     = st_q.sel_a;
    assign sel_b     = st_q.sel_b;
    assign pre_val   = st_q.pre;
    assign post_val  = st_q.post;
    assign enable    = st_q.en;
    assign reject    = st_q.rej;
    assign stale_err = st_q.err;
endmodule

// File: rtl/ppc_branch.sv
module ppc_branch #(
    parameter int N_SRC  = 8,
    parameter int SEL_W  = 3,
    parameter int PRE_W  = 3,
    parameter bit BYPASS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             gate_open,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_val,
    output logic             hit
);
    logic gated_tick;
    assign gated_tick = gate_open && src_tick[sel];

    if (BYPASS) begin : g_core
        assign hit = gated_tick;
    end else begin : g_prediv
        logic [PRE_W-1:0] cnt_d, cnt_q;
        logic             hit_c;

        always_comb begin
            cnt_d = cnt_q;
            hit_c = 1'b0;
            if (!gate_open || restart) begin
                cnt_d = '0;
            end else if (gated_tick) begin
                if (cnt_q == pre_val) begin
                    hit_c = 1'b1;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign hit = hit_c;
    end
endmodule

// File: rtl/ppc_postdiv.sv
module ppc_postdiv #(
    parameter int POST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick_in,
    input  logic              restart,
    input  logic [POST_W-1:0] div_val,
    output logic              tick_out
);
    typedef struct packed {
        logic [POST_W-1:0] cnt;
        logic              out;
    } post_t;

    post_t pd_d, pd_q;

    always_comb begin
        pd_d     = pd_q;
        pd_d.out = 1'b0;
        if (!enable || restart) begin
            pd_d.cnt = '0;
        end else if (tick_in) begin
            if (pd_q.cnt == div_val) begin
                pd_d.out = 1'b1;
                pd_d.cnt = '0;
            end else begin
                pd_d.cnt = pd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    assign tick_out = pd_q.out;
endmodule

// File: rtl/ppc_clk_root.sv
module ppc_clk_root #(
    parameter int N_SRC  = 8,
    parameter int PRE_W  = 3,
    parameter int POST_W = 6,
    parameter bit CORE   = 1'b0,
    localparam int SEL_W  = $clog2(N_SRC),
    localparam int DATA_W = (POST_W > PRE_W) ? POST_W : PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_tick,
    input  logic [N_SRC-1:0]  src_valid,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              clk_out_tick,
    output logic              rd_active,
    output logic [SEL_W-1:0]  rd_sel_a,
    output logic [SEL_W-1:0]  rd_sel_b,
    output logic              wr_reject,
    output logic              err_src_inactive
);
    logic              active;
    logic [SEL_W-1:0]  sel_a, sel_b;
    logic [PRE_W-1:0]  pre_val;
    logic [POST_W-1:0] post_val;
    logic              enable;
    logic [1:0]        restart_br;
    logic              restart_post;
    logic [SEL_W-1:0]  br_sel [2];
    logic [1:0]        br_open;
    logic [1:0]        br_hit;
    logic              mux_tick;

    ppc_ctrl #(
        .N_SRC(N_SRC), .SEL_W(SEL_W), .PRE_W(PRE_W),
        .POST_W(POST_W), .DATA_W(DATA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .active(active), .sel_a(sel_a), .sel_b(sel_b),
        .pre_val(pre_val), .post_val(post_val), .enable(enable),
        .restart_br(restart_br), .restart_post(restart_post),
        .reject(wr_reject), .stale_err(err_src_inactive)
    );

    assign br_sel[0]  = sel_a;
    assign br_sel[1]  = sel_b;
    assign br_open[0] = enable && !active;
    assign br_open[1] = enable && active;

    for (genvar b = 0; b < 2; b++) begin : g_branch
        ppc_branch #(
            .N_SRC(N_SRC), .SEL_W(SEL_W), .PRE_W(PRE_W), .BYPASS(CORE)
        ) u_br (
            .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
            .sel(br_sel[b]), .gate_open(br_open[b]),
            .restart(restart_br[b]), .pre_val(pre_val),
            .hit(br_hit[b])
        );
    end

    assign mux_tick = active ? br_hit[1] : br_hit[0];

    ppc_postdiv #(.POST_W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick_in(mux_tick),
        .restart(restart_post), .div_val(post_val), .tick_out(clk_out_tick)
    );

    assign rd_active = active;
    assign rd_sel_a  = sel_a;
    assign rd_sel_b  = sel_b;
endmodule

// File: rtl/ppc_clk_root_chk.sv
module ppc_clk_root_chk #(
    parameter int N_SRC  = 8,
    parameter int DATA_W = 6,
    localparam int SEL_W = $clog2(N_SRC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_valid,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              clk_out_tick,
    input logic              rd_active,
    input logic [SEL_W-1:0]  rd_sel_a,
    input logic [SEL_W-1:0]  rd_sel_b,
    input logic              wr_reject,
    input logic              err_src_inactive
);
    logic             src_wr;
    logic [SEL_W-1:0] idx;
    logic [SEL_W-1:0] idle_sel;
    assign src_wr   = wr_en && (wr_addr == 2'd0);
    assign idx      = wr_data[SEL_W-1:0];
    assign idle_sel = rd_active ? rd_sel_a : rd_sel_b;

    assert_flip_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && src_valid[idx]) |=> (rd_active != $past(rd_active)));

    assert_write_b_when_a_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && src_valid[idx] && !rd_active) |=>
            (rd_sel_b == $past(idx) && $stable(rd_sel_a)));

    assert_write_a_when_b_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && src_valid[idx] && rd_active) |=>
            (rd_sel_a == $past(idx) && $stable(rd_sel_b)));

    assert_hold_without_src_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !src_wr |=> ($stable(rd_active) && $stable(rd_sel_a) && $stable(rd_sel_b)));

    assert_reject_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && !src_valid[idx]) |=>
            (wr_reject && $stable(rd_active) && $stable(rd_sel_a) && $stable(rd_sel_b)));

    assert_stale_idle_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && !src_valid[idle_sel]) |=> err_src_inactive);

    assert_no_spurious_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !src_wr |=> !err_src_inactive && !wr_reject);

    assert_disable_quiets_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && !wr_data[0]) |=> ##1 !clk_out_tick);
endmodule

bind ppc_clk_root ppc_clk_root_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .clk_out_tick(clk_out_tick),
    .rd_active(rd_active), .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b),
    .wr_reject(wr_reject), .err_src_inactive(err_src_inactive)
);

// File: tb/sim_ppc_clk_root.sv
`timescale 1ns/100ps
module sim_ppc_clk_root;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_tick = '0;
    logic [7:0] src_valid = 8'hFF;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       out0, act0, rej0, err0;
    logic [2:0] sa0, sb0;
    logic       out1, act1, rej1, err1;
    logic [2:0] sa1, sb1;
    int n_tests = 0;
    int n_fail  = 0;
    int cnt0 = 0;
    int cnt1 = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ppc_clk_root u0 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_valid(src_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_out_tick(out0), .rd_active(act0), .rd_sel_a(sa0), .rd_sel_b(sb0),
        .wr_reject(rej0), .err_src_inactive(err0)
    );

    ppc_clk_root #(.CORE(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .src_valid(src_valid),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clk_out_tick(out1), .rd_active(act1), .rd_sel_a(sa1), .rd_sel_b(sb1),
        .wr_reject(rej1), .err_src_inactive(err1)
    );

    always @(negedge clk) begin
        if (out0) cnt0++;
        if (out1) cnt1++;
    end

    // {valid, idx, exp_active, exp_sel_a, exp_sel_b, exp_reject, exp_err}
    localparam logic [31:0] VEC [8] = '{
        32'hFF110100, 32'hFF101100, 32'hFF211200, 32'hDF511210,
        32'hFD404201, 32'hFF714700, 32'hFF707700, 32'h7F707711
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input logic [7:0] mask, input int n);
        cnt0 = 0; cnt1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick = mask;
        end
        @(negedge clk);
        src_tick = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset readback/flags/out", {act0, sa0, sb0, rej0, err0, out0}, 0);

        // R2 R3 R4 R5: steering table
        for (int v = 0; v < 8; v++) begin
            src_valid = VEC[v][31:24];
            wr(2'd0, {3'b0, VEC[v][22:20]});
            check($sformatf("R2/R3/R4/R5 vector %0d", v),
                  {act0, 1'b0, sa0, 1'b0, sb0, 3'b0, rej0, 3'b0, err0},
                  VEC[v][19:0]);
        end
        src_valid = 8'hFF;

        // R6: divide by 1, source 3 on both branches
        wr(2'd3, 6'd1);
        wr(2'd0, 6'd3);
        wr(2'd0, 6'd3);
        run(8'h08, 10);
        check("R6 divide by 1", cnt0, 10);

        // R6/R7: pre=1 post=2
        wr(2'd1, 6'd1);
        wr(2'd2, 6'd2);
        run(8'h08, 30);
        check("R6 divide by 6", cnt0, 5);
        check("R7 core variant divide by 3", cnt1, 10);

        // R9: B now on source 5, ticks on idle-branch source 3 ignored
        wr(2'd0, 6'd5);
        run(8'h08, 30);
        check("R9 idle source ignored", cnt0, 0);
        run(8'h20, 30);
        check("R9 driving source counted", cnt0, 5);

        // R10: rewrite same divide values mid-count
        run(8'h20, 5);
        wr(2'd1, 6'd1);
        wr(2'd2, 6'd2);
        run(8'h20, 5);
        check("R10 restart leaves no carried count", cnt0, 0);
        run(8'h20, 1);
        check("R10 pulse after full fresh period", cnt0, 1);

        // R8: disabled output stays low, selects untouched
        wr(2'd3, 6'd0);
        run(8'hFF, 12);
        check("R8 output low when disabled", cnt0, 0);
        check("R8 readback unchanged", {act0, sa0, sb0}, {1'b1, 3'd3, 3'd5});

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule